// File: doc/BRIEF.md
# Speculative Reorder Buffer with In-Order Retirement

This block keeps finished-but-unretired instruction results in a circular buffer so that execution may finish out of order while architectural state changes strictly in program order. Each issuing instruction claims the slot at the tail. The index of that slot becomes the tag under which a functional unit later broadcasts the result on the shared result bus. The buffer captures the broadcast into the slot. Until the slot retires, any newly issuing instruction can read its value by tag. A lookup also sees a result that is arriving on the bus in the same cycle.

The oldest slot retires only once its result is present. A register-kind slot then drives the register-file write port. A store-kind slot drives the memory store port. A branch that was predicted correctly retires with no write. A result flagged as bad reaches the head either as a mispredicted branch or as an excepting instruction. When it does, the block raises `squash` for one cycle and discards every slot. It also returns both pointers to slot 0.

A small rename map is kept per architectural register. It records which slot will produce that register's next value. Issue-stage logic uses this map to decide whether to read an operand from the register file or from the buffer.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `alloc_ok` is 1, `alloc_tag` is 0, `rf_we`, `st_we` and `squash` are 0, every lookup returns not ready and every register reads as not pending.
- R2: Allocation takes the tail slot and hands out tags 0,1,..,DEPTH-1 in order with wraparound, one per cycle. With DEPTH slots occupied, `alloc_ok` is 0 and a request is ignored: no slot is taken, the tag does not move and the rename map is unchanged.
- R3: A result on the bus (`res_valid`) with tag t is stored in slot t. From the next cycle on, a lookup of t returns ready and that value.
- R4: A lookup of a slot whose result has not arrived returns not ready. A lookup whose tag matches a bus result in the same cycle returns ready and the bus value.
- R5: Only the head slot retires, and only once its result is present. A completed younger slot waits behind an incomplete head.
- R6: A retiring register slot (kind code 0) drives `rf_we`=1, with `rf_addr` taken from the low REG_W bits of its destination and `rf_data` taken from its value.
- R7: A retiring store slot (kind code 1) drives `st_we`=1, with `st_addr` taken from its destination and `st_data` taken from its value.
- R8: A retiring branch slot (kind code 2 or 3) without the bad flag produces no write and frees its slot.
- R9: A completed head slot whose result carried `res_bad`=1 raises `squash` for one cycle with no write. On the next cycle all slots are gone: lookups return not ready, `alloc_tag` is 0 and no register is pending.
- R10: Allocating a register slot marks that register pending on the new tag. Retiring the slot clears the mark only if the register still points at that tag.
- R11: An allocation and a retirement may happen in the same cycle. At most one of `rf_we`, `st_we`, `squash` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Issue stage requests a slot |
| alloc_kind | input | 2 | 0 register, 1 store, 2/3 branch |
| alloc_dest | input | DEST_W | Register number or store address |
| alloc_ok | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAG_W | Tag of the slot taken on a granted request |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | TAG_W | Slot the result belongs to |
| res_value | input | DATA_W | Result value |
| res_bad | input | 1 | Mispredicted branch or exception |
| look_tag | input | TAG_W | Operand lookup tag |
| look_ready | output | 1 | Looked-up value is available |
| look_value | output | DATA_W | Looked-up value |
| src_reg | input | REG_W | Register queried in the rename map |
| src_busy | output | 1 | Register awaits an unretired slot |
| src_tag | output | TAG_W | Slot producing that register |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | REG_W | Register-file write address |
| rf_data | output | DATA_W | Register-file write data |
| st_we | output | 1 | Store write enable |
| st_addr | output | DEST_W | Store address |
| st_data | output | DATA_W | Store data |
| squash | output | 1 | Buffer discarded this cycle |

## Verification
The assertions assume that the result bus only carries tags that are currently allocated and not yet completed, with at most one result per cycle. They also assume that `alloc_kind` stays within the four listed codes. The stimulus respects this by broadcasting only tags that the bench recorded from `alloc_tag` and has not yet seen retire. Each such tag is sent once. The bench never broadcasts during a cycle in which it expects `squash`.

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NREG  = 1 << REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  output logic              alloc_ok,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_bad,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              look_ready,
  output logic [DATA_W-1:0] look_value,
  input  logic [REG_W-1:0]  src_reg,
  output logic              src_busy,
  output logic [TAG_W-1:0]  src_tag,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_we,
  output logic [DEST_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              squash
);

  localparam logic [1:0] KIND_REG = 2'd0;
  localparam logic [1:0] KIND_ST  = 2'd1;

  logic              e_valid [DEPTH];
  logic              e_ready [DEPTH];
  logic              e_bad   [DEPTH];
  logic [1:0]        e_kind  [DEPTH];
  logic [DEST_W-1:0] e_dest  [DEPTH];
  logic [DATA_W-1:0] e_val   [DEPTH];

  logic              map_busy [NREG];
  logic [TAG_W-1:0]  map_tag  [NREG];

  logic [TAG_W-1:0]  head, tail, head_nx, tail_nx;
  logic [CNT_W-1:0]  count;
  logic              head_done, retire, fire, bus_hit;
  logic [REG_W-1:0]  head_reg, alloc_reg;

  assign head_nx   = (head == TAG_W'(DEPTH - 1)) ? '0 : head + 1'b1;
  assign tail_nx   = (tail == TAG_W'(DEPTH - 1)) ? '0 : tail + 1'b1;
  assign head_done = e_valid[head] & e_ready[head];
  assign squash    = head_done & e_bad[head];
  assign retire    = head_done & ~e_bad[head];
  assign alloc_ok  = (count != CNT_W'(DEPTH)) & ~squash;
  assign fire      = alloc_req & alloc_ok;
  assign alloc_tag = tail;
  assign head_reg  = e_dest[head][REG_W-1:0];
  assign alloc_reg = alloc_dest[REG_W-1:0];

  assign rf_we   = retire & (e_kind[head] == KIND_REG);
  assign rf_addr = head_reg;
  assign rf_data = e_val[head];
  assign st_we   = retire & (e_kind[head] == KIND_ST);
  assign st_addr = e_dest[head];
  assign st_data = e_val[head];

  assign bus_hit    = res_valid & (res_tag == look_tag);
  assign look_ready = e_valid[look_tag] & (e_ready[look_tag] | bus_hit);
  assign look_value = (bus_hit & ~e_ready[look_tag]) ? res_value : e_val[look_tag];

  assign src_busy = map_busy[src_reg];
  assign src_tag  = map_tag[src_reg];

  always_ff @(posedge clk) begin
    if (!rst_n || squash) begin
      for (int i = 0; i < DEPTH; i++) begin
        e_valid[i] <= 1'b0;
        e_ready[i] <= 1'b0;
        e_bad[i]   <= 1'b0;
      end
      for (int r = 0; r < NREG; r++) begin
        map_busy[r] <= 1'b0;
        map_tag[r]  <= '0;
      end
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (retire) begin
        e_valid[head] <= 1'b0;
        head <= head_nx;
        if (e_kind[head] == KIND_REG && map_busy[head_reg] && map_tag[head_reg] == head)
          map_busy[head_reg] <= 1'b0;
      end
      if (fire) begin
        e_valid[tail] <= 1'b1;
        e_ready[tail] <= 1'b0;
        e_bad[tail]   <= 1'b0;
        e_kind[tail]  <= alloc_kind;
        e_dest[tail]  <= alloc_dest;
        tail <= tail_nx;
        if (alloc_kind == KIND_REG) begin
          map_busy[alloc_reg] <= 1'b1;
          map_tag[alloc_reg]  <= tail;
        end
      end
      if (res_valid && e_valid[res_tag]) begin
        e_ready[res_tag] <= 1'b1;
        e_val[res_tag]   <= res_value;
        e_bad[res_tag]   <= res_bad;
      end
      count <= count + CNT_W'(fire) - CNT_W'(retire);
    end
  end

endmodule

module spec_rob_chk #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             alloc_req,
  input logic             alloc_ok,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             rf_we,
  input logic             st_we,
  input logic             squash
);

  // R2
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !alloc_ok);

  // R2
  tag_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_ok) |=>
      alloc_tag == (($past(alloc_tag) == TAG_W'(DEPTH - 1)) ? '0 : $past(alloc_tag) + 1'b1));

  // R11
  single_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, st_we, squash}));

  // R9
  squash_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (count == '0 && alloc_tag == '0 && !rf_we && !st_we && !squash));

endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .alloc_req(alloc_req),
  .alloc_ok(alloc_ok), .alloc_tag(alloc_tag), .rf_we(rf_we),
  .st_we(st_we), .squash(squash)
);

// File: tb/spec_rob_test.sv
`timescale 1ns/1ps
module spec_rob_test;
  localparam int DEPTH = 4, DATA_W = 32, DEST_W = 16, REG_W = 5, TAG_W = 2;
  localparam logic [1:0] K_REG = 2'd0, K_ST = 2'd1, K_BR = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_req = 1'b0, res_valid = 1'b0, res_bad = 1'b0;
  logic [1:0] alloc_kind = '0;
  logic [DEST_W-1:0] alloc_dest = '0;
  logic [TAG_W-1:0] res_tag = '0, look_tag = '0;
  logic [DATA_W-1:0] res_value = '0;
  logic [REG_W-1:0] src_reg = '0;
  logic alloc_ok, look_ready, src_busy, rf_we, st_we, squash;
  logic [TAG_W-1:0] alloc_tag, src_tag;
  logic [DATA_W-1:0] look_value, rf_data, st_data;
  logic [REG_W-1:0] rf_addr;
  logic [DEST_W-1:0] st_addr;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  spec_rob #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .REG_W(REG_W)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value), .res_bad(res_bad),
    .look_tag(look_tag), .look_ready(look_ready), .look_value(look_value),
    .src_reg(src_reg), .src_busy(src_busy), .src_tag(src_tag),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data), .squash(squash));

  typedef struct packed {
    logic a_req; logic [1:0] a_kind; logic [7:0] a_dest;
    logic c_v; logic [1:0] c_tag; logic [7:0] c_val; logic c_bad;
    logic x_rf; logic x_st; logic x_sq; logic [1:0] x_tag;
    logic [7:0] x_addr; logic [7:0] x_data;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, K_REG, 8'h03, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00},
    '{1'b1, K_ST,  8'h40, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00, 8'h00},
    '{1'b1, K_REG, 8'h05, 1'b1, 2'd1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00, 8'h00},
    '{1'b0, K_REG, 8'h00, 1'b1, 2'd0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 8'h00},
    '{1'b0, K_REG, 8'h00, 1'b1, 2'd2, 8'h33, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 8'h03, 8'h11},
    '{1'b0, K_REG, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 8'h40, 8'h22},
    '{1'b0, K_REG, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 8'h05, 8'h33},
    '{1'b0, K_REG, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic adv;
    @(posedge clk); #1;
  endtask

  task automatic idle;
    alloc_req = 1'b0; res_valid = 1'b0; res_bad = 1'b0;
  endtask

  task automatic alloc(input logic [1:0] k, input logic [15:0] d);
    alloc_req = 1'b1; alloc_kind = k; alloc_dest = d;
  endtask

  task automatic post(input logic [1:0] t, input logic [31:0] v, input logic bad);
    res_valid = 1'b1; res_tag = t; res_value = v; res_bad = bad;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    adv; adv;
    // R1 reset state
    chk("R1", "alloc_ok", alloc_ok, 1); chk("R1", "alloc_tag", alloc_tag, 0);
    chk("R1", "commit", {rf_we, st_we, squash}, 0);
    chk("R1", "look_ready", look_ready, 0); chk("R1", "src_busy", src_busy, 0);
    rst_n = 1'b1;
    adv;

    // R2 R3 R5 R6 R7: vector walk
    for (int i = 0; i < 8; i++) begin
      alloc_req = VEC[i].a_req; alloc_kind = VEC[i].a_kind; alloc_dest = 16'(VEC[i].a_dest);
      res_valid = VEC[i].c_v; res_tag = VEC[i].c_tag; res_value = 32'(VEC[i].c_val); res_bad = VEC[i].c_bad;
      #1;
      chk("R2", "alloc_tag", alloc_tag, VEC[i].x_tag);
      chk("R6", "rf_we", rf_we, VEC[i].x_rf);
      chk("R7", "st_we", st_we, VEC[i].x_st);
      chk("R5", "squash", squash, VEC[i].x_sq);
      if (VEC[i].x_rf) begin
        chk("R6", "rf_addr", rf_addr, VEC[i].x_addr); chk("R6", "rf_data", rf_data, VEC[i].x_data);
      end
      if (VEC[i].x_st) begin
        chk("R7", "st_addr", st_addr, VEC[i].x_addr); chk("R7", "st_data", st_data, VEC[i].x_data);
      end
      adv;
    end
    idle;

    // R2 fill to full with branches: tags 3,0,1,2
    for (int i = 0; i < DEPTH; i++) begin
      alloc(K_BR, 16'h0);
      #1; chk("R2", "fill tag", alloc_tag, (3 + i) % DEPTH); chk("R2", "fill ok", alloc_ok, 1);
      adv;
    end
    alloc(K_REG, 16'd9);
    #1; chk("R2", "full alloc_ok", alloc_ok, 0); chk("R2", "full tag", alloc_tag, 3);
    adv; idle;
    src_reg = 5'd9; look_tag = 2'd0;
    #1; chk("R2", "ignored rename", src_busy, 0); chk("R2", "tag held", alloc_tag, 3);
    chk("R4", "not ready", look_ready, 0);
    post(2'd0, 32'hAB, 1'b0);
    #1; chk("R4", "bypass ready", look_ready, 1); chk("R4", "bypass value", look_value, 32'hAB);
    adv; idle;
    #1; chk("R3", "captured ready", look_ready, 1); chk("R3", "captured value", look_value, 32'hAB);
    chk("R5", "younger waits", {rf_we, st_we, squash}, 0);
    post(2'd3, 32'h0, 1'b0);
    adv; idle;
    #1; chk("R8", "branch no write", {rf_we, st_we, squash}, 0); chk("R2", "still full", alloc_ok, 0);
    post(2'd1, 32'h0, 1'b1);
    adv; post(2'd2, 32'h55, 1'b0);
    #1; chk("R8", "branch freed slot", alloc_ok, 1); chk("R8", "no write", {rf_we, st_we, squash}, 0);
    adv; idle; look_tag = 2'd2;
    #1; chk("R9", "mispredict squash", squash, 1); chk("R9", "no rf write", rf_we, 0);
    chk("R3", "tag2 ready pre-squash", look_value, 32'h55);
    adv;
    #1; chk("R9", "discarded", look_ready, 0); chk("R9", "tag reset", alloc_tag, 0);
    chk("R9", "alloc_ok", alloc_ok, 1); chk("R9", "squash pulse", squash, 0);

    // R10 rename map
    alloc(K_REG, 16'd7);
    adv; src_reg = 5'd7;
    #1; chk("R10", "busy", src_busy, 1); chk("R10", "tag0", src_tag, 0);
    adv; idle;
    #1; chk("R10", "remapped", src_tag, 1);
    post(2'd0, 32'h70, 1'b0);
    adv; idle;
    #1; chk("R6", "rf_we", rf_we, 1); chk("R6", "rf_addr", rf_addr, 7); chk("R6", "rf_data", rf_data, 32'h70);
    adv; post(2'd1, 32'h71, 1'b0);
    #1; chk("R10", "kept newer", src_busy, 1); chk("R10", "kept tag", src_tag, 1);
    adv; idle; alloc(K_REG, 16'd4);
    #1; chk("R11", "commit with alloc", rf_we, 1); chk("R11", "alloc_ok", alloc_ok, 1);
    chk("R11", "tag2", alloc_tag, 2); chk("R6", "rf_data", rf_data, 32'h71);
    adv; idle;
    #1; chk("R10", "cleared", src_busy, 0);
    src_reg = 5'd4;
    #1; chk("R10", "reg4 busy", src_busy, 1); chk("R10", "reg4 tag", src_tag, 2);
    post(2'd2, 32'h0, 1'b1);
    adv; idle;
    #1; chk("R9", "exception squash", squash, 1); chk("R9", "no write", rf_we, 0);
    adv;
    #1; chk("R9", "map cleared", src_busy, 0); chk("R9", "tag0", alloc_tag, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule